// File: doc/BRIEF.md
# Host Bridge Control Register File

This block holds the 64-bit configuration and status registers of a host bridge and serves them to two requesters. A side-band scan path reaches the registers by index `addr >> 3`. A memory-mapped path reaches the same storage shifted by ten, at index `(addr >> 3) + 0x0A`, so the memory-mapped path cannot reach the low indices. Every access is a full eight-byte word. An access of any other size is rejected.

Besides plain read/write registers, the file has write-only alias indices. These apply a bitwise AND or OR to the fault register, or set or clear bits of the control register, in a single access. There is no read-modify-write on the requester side. The window base register chooses where the bridge decodes its memory window. The block drives that decision continuously on `window_valid` and `window_base`. Only the scan path may move the window.

Each request gets a response one cycle later, with the read data and a one-cycle error flag.

Top module: `hbcr_regfile`

## Requirements
- R1: A request presented with `req_valid` gets `rsp_valid` exactly one cycle later. The index is `addr >> 3` on the scan path (`req_path`=0) and `(addr >> 3) + 0x0A` on the memory-mapped path (`req_path`=1). Read data appears on `rsp_rdata`, and a write returns zero there.
- R2: Index 0x00 is the fault register, readable and writable. A write to index 0x01 ANDs the data into it, and a write to index 0x02 ORs the data into it.
- R3: Index 0x0E is the control register, readable and writable. A write to index 0x12 ORs the data into it, and a write to index 0x13 clears every bit that is one in the data.
- R4: Index 0x0A is the window base register. A write keeps only bits 49:20 and bit 0. Bit 0 drives `window_valid`, and `window_base` carries bits 49:20 with all other bits zero. Both outputs change in the cycle after the write.
- R5: A write to index 0x0A from the memory-mapped path changes nothing and raises the error flag. A read of it from either path is allowed.
- R6: Index 0x0B keeps only bits 49:32 of the written value.
- R7: Index 0x15 is the interrupt status register. It reads as zero, and a write to it changes nothing and raises the error flag.
- R8: A read of an index that is not readable, including the alias indices 0x01, 0x02, 0x12 and 0x13, returns all ones and raises the error flag. A write to an unimplemented index changes no register and raises the error flag.
- R9: An access whose `req_size` is not 8 changes no register, returns all ones on a read, and raises the error flag.
- R10: After reset, every register reads zero except the window base. The window base holds the `BASE_DEFAULT` parameter masked as in R4, with bit 0 set, so `window_valid` is 1.
- R11: `err_pulse` is high for one cycle, only together with `rsp_valid`, and stays low for every legal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_path | input | 1 | 0 = scan path, 1 = memory-mapped path |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 4 | Access size in bytes; only 8 is legal |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Read data, all ones on a rejected read |
| err_pulse | output | 1 | One-cycle error flag for a rejected access |
| window_valid | output | 1 | Decoded window enabled |
| window_base | output | 64 | Decoded window base address |

## Verification
The bench targets the accesses that look legal but must be refused. These are a window base write from the memory-mapped path, a write to the status register, a read of a write-only alias, and a short access to a real register. A design that ignores the path would let the window jump. A design that treats aliases as storage would return stale data instead of all ones. The bench also confirms that the memory-mapped offset lands on the same storage as the scan path, since an off-by-one offset aims every write at the neighbouring register. It checks that set, clear, AND and OR combine with the old contents rather than overwrite them.

// File: rtl/hbcr_pkg.sv
package hbcr_pkg;
  localparam int DATA_W   = 64;
  localparam int ACC_SIZE = 8;
  localparam int MMIO_OFS = 'h0A;

  localparam int IDX_FAULT     = 'h00;
  localparam int IDX_FAULT_AND = 'h01;
  localparam int IDX_FAULT_OR  = 'h02;
  localparam int IDX_BASE      = 'h0A;
  localparam int IDX_SIDE_BASE = 'h0B;
  localparam int IDX_CTRL      = 'h0E;
  localparam int IDX_CTRL_SET  = 'h12;
  localparam int IDX_CTRL_CLR  = 'h13;
  localparam int IDX_ISTAT     = 'h15;

  localparam int BASE_LO = 20;
  localparam int BASE_HI = 49;
  localparam int SIDE_LO = 32;

  localparam logic [DATA_W-1:0] BASE_ADDR_MASK =
    ((64'd1 << (BASE_HI + 1)) - 64'd1) & ~((64'd1 << BASE_LO) - 64'd1);
  localparam logic [DATA_W-1:0] BASE_KEEP = BASE_ADDR_MASK | 64'd1;
  localparam logic [DATA_W-1:0] SIDE_KEEP =
    ((64'd1 << (BASE_HI + 1)) - 64'd1) & ~((64'd1 << SIDE_LO) - 64'd1);

  typedef enum logic [3:0] {
    K_FAULT, K_FAULT_AND, K_FAULT_OR, K_BASE, K_SIDE,
    K_CTRL, K_CTRL_SET, K_CTRL_CLR, K_ISTAT, K_NONE
  } reg_kind_e;
endpackage

// File: rtl/hbcr_decode.sv
module hbcr_decode
  import hbcr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              path,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  output reg_kind_e         kind,
  output logic              reject
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] idx;
  logic          rd_ok;
  logic          wr_ok;

  always_comb begin
    idx = {1'b0, addr[ADDR_W-1:3]} + (path ? IW'(MMIO_OFS) : IW'(0));
    case (idx)
      IW'(IDX_FAULT):     kind = K_FAULT;
      IW'(IDX_FAULT_AND): kind = K_FAULT_AND;
      IW'(IDX_FAULT_OR):  kind = K_FAULT_OR;
      IW'(IDX_BASE):      kind = K_BASE;
      IW'(IDX_SIDE_BASE): kind = K_SIDE;
      IW'(IDX_CTRL):      kind = K_CTRL;
      IW'(IDX_CTRL_SET):  kind = K_CTRL_SET;
      IW'(IDX_CTRL_CLR):  kind = K_CTRL_CLR;
      IW'(IDX_ISTAT):     kind = K_ISTAT;
      default:            kind = K_NONE;
    endcase
  end

  always_comb begin
    rd_ok = (kind == K_FAULT) || (kind == K_BASE) || (kind == K_SIDE) ||
            (kind == K_CTRL) || (kind == K_ISTAT);
    wr_ok = (kind == K_FAULT) || (kind == K_FAULT_AND) || (kind == K_FAULT_OR) ||
            (kind == K_SIDE) || (kind == K_CTRL) || (kind == K_CTRL_SET) ||
            (kind == K_CTRL_CLR) || ((kind == K_BASE) && !path);
    reject = (size != 4'(ACC_SIZE)) || (write ? !wr_ok : !rd_ok);
  end
endmodule

// File: rtl/hbcr_regs.sv
module hbcr_regs
  import hbcr_pkg::*;
#(
  parameter logic [63:0] BASE_DEFAULT = 64'h0000_0006_0030_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  reg_kind_e         kind,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] fault_q,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] side_q,
  output logic [DATA_W-1:0] ctrl_q
);
  localparam logic [DATA_W-1:0] BASE_RST = (BASE_DEFAULT & BASE_KEEP) | 64'd1;

  logic [DATA_W-1:0] fault_d, base_d, side_d, ctrl_d;

  always_comb begin
    fault_d = fault_q;
    base_d  = base_q;
    side_d  = side_q;
    ctrl_d  = ctrl_q;
    case (kind)
      K_FAULT:     fault_d = wdata;
      K_FAULT_AND: fault_d = fault_q & wdata;
      K_FAULT_OR:  fault_d = fault_q | wdata;
      K_BASE:      base_d  = wdata & BASE_KEEP;
      K_SIDE:      side_d  = wdata & SIDE_KEEP;
      K_CTRL:      ctrl_d  = wdata;
      K_CTRL_SET:  ctrl_d  = ctrl_q | wdata;
      K_CTRL_CLR:  ctrl_d  = ctrl_q & ~wdata;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= '0;
      base_q  <= BASE_RST;
      side_q  <= '0;
      ctrl_q  <= '0;
    end else if (we) begin
      fault_q <= fault_d;
      base_q  <= base_d;
      side_q  <= side_d;
      ctrl_q  <= ctrl_d;
    end
  end
endmodule

// File: rtl/hbcr_regfile.sv
module hbcr_regfile
  import hbcr_pkg::*;
#(
  parameter int          ADDR_W       = 10,
  parameter logic [63:0] BASE_DEFAULT = 64'h0000_0006_0030_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_path,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              err_pulse,
  output logic              window_valid,
  output logic [63:0]       window_base
);
  reg_kind_e         kind;
  logic              reject;
  logic [DATA_W-1:0] fault_q, base_q, side_q, ctrl_q;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_d;

  hbcr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .path   (req_path),
    .write  (req_write),
    .addr   (req_addr),
    .size   (req_size),
    .kind   (kind),
    .reject (reject)
  );

  hbcr_regs #(.BASE_DEFAULT(BASE_DEFAULT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (req_valid && req_write && !reject),
    .kind    (kind),
    .wdata   (req_wdata),
    .fault_q (fault_q),
    .base_q  (base_q),
    .side_q  (side_q),
    .ctrl_q  (ctrl_q)
  );

  always_comb begin
    case (kind)
      K_FAULT: rd_val = fault_q;
      K_BASE:  rd_val = base_q;
      K_SIDE:  rd_val = side_q;
      K_CTRL:  rd_val = ctrl_q;
      default: rd_val = '0;
    endcase
    if (req_write)   rdata_d = '0;
    else if (reject) rdata_d = '1;
    else             rdata_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      err_pulse <= req_valid && reject;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rsp_rdata <= '0;
    else if (req_valid) rsp_rdata <= rdata_d;
  end

  assign window_valid = base_q[0];
  assign window_base  = base_q & BASE_ADDR_MASK;
endmodule

// File: rtl/hbcr_regfile_chk.sv
module hbcr_regfile_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_path,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_size,
  input logic [63:0]       req_wdata,
  input logic              rsp_valid,
  input logic [63:0]       rsp_rdata,
  input logic              err_pulse,
  input logic              window_valid,
  input logic [63:0]       window_base,
  input logic [63:0]       fault_q,
  input logic [63:0]       ctrl_q
);
  logic scan_w8;
  assign scan_w8 = req_valid && req_write && !req_path && (req_size == 4'd8);

  a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r11_err_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> rsp_valid);
  a_r9_size_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 4'd8) |=> err_pulse);
  a_r5_mmio_base_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_path && req_addr[ADDR_W-1:3] == '0)
    |=> (err_pulse && $stable(window_base) && $stable(window_valid)));
  a_r3_ctrl_set: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_w8 && req_addr[ADDR_W-1:3] == (ADDR_W-3)'('h12))
    |=> ctrl_q == ($past(ctrl_q) | $past(req_wdata)));
  a_r2_fault_and: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_w8 && req_addr[ADDR_W-1:3] == (ADDR_W-3)'('h01))
    |=> fault_q == ($past(fault_q) & $past(req_wdata)));
  a_r8_reject_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size != 4'd8) |=> (&rsp_rdata));
endmodule

bind hbcr_regfile hbcr_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_path     (req_path),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .req_size     (req_size),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .err_pulse    (err_pulse),
  .window_valid (window_valid),
  .window_base  (window_base),
  .fault_q      (fault_q),
  .ctrl_q       (ctrl_q)
);

// File: tb/hbcr_regfile_test.sv
`timescale 1ns/1ps
module hbcr_regfile_test;
  localparam int          AW      = 10;
  localparam logic [63:0] DEF     = 64'h0000_0006_0030_0000;
  localparam logic [63:0] ADDRMSK = 64'h0003_FFFF_FFF0_0000;
  localparam logic [63:0] SIDEMSK = 64'h0003_FFFF_0000_0000;
  localparam logic [63:0] ONES    = {64{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_path = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_size = 4'd8;
  logic [63:0]   req_wdata = '0;
  logic          rsp_valid, err_pulse, window_valid;
  logic [63:0]   rsp_rdata, window_base;

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] rd;
  logic        er;

  always #4 clk = ~clk;

  hbcr_regfile #(.ADDR_W(AW), .BASE_DEFAULT(DEF)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_path(req_path),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .err_pulse(err_pulse), .window_valid(window_valid), .window_base(window_base)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic path, input logic wr, input int idx,
                     input logic [63:0] d, input logic [3:0] sz = 4'd8);
    int ofs;
    ofs = path ? idx - 'h0A : idx;
    @(negedge clk);
    req_valid = 1'b1; req_path = path; req_write = wr;
    req_addr = AW'(ofs * 8); req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd1);
    rd = rsp_rdata; er = err_pulse;
    @(negedge clk);
    check("R11 err one cycle", {63'd0, err_pulse}, 64'd0);
  endtask

  task automatic t_reset;
    check("R10 window_valid", {63'd0, window_valid}, 64'd1);
    check("R10 window_base", window_base, DEF & ADDRMSK);
    acc(0, 0, 'h0A, 0); check("R10 base read", rd, (DEF & ADDRMSK) | 64'd1);
    acc(0, 0, 'h00, 0); check("R10 fault zero", rd, 64'd0);
    acc(0, 0, 'h0E, 0); check("R10 ctrl zero", rd, 64'd0);
    check("R11 no err legal", {63'd0, er}, 64'd0);
  endtask

  task automatic t_fault;
    acc(0, 1, 'h00, 64'hF0F0_0000_FFFF_1234);
    acc(0, 1, 'h01, 64'hFF00_FF00_0F0F_FFFF);
    acc(0, 0, 'h00, 0); check("R2 fault and", rd, 64'hF000_0000_0F0F_1234);
    acc(0, 1, 'h02, 64'h0000_0001_0000_0001);
    acc(0, 0, 'h00, 0); check("R2 fault or", rd, 64'hF000_0001_0F0F_1235);
    acc(0, 0, 'h01, 0); check("R8 alias read ones", rd, ONES);
    check("R8 alias read err", {63'd0, er}, 64'd1);
  endtask

  task automatic t_ctrl;
    acc(1, 1, 'h0E, 64'h8000_0000_0000_00A0);
    acc(1, 1, 'h12, 64'h0400_0000_0000_000F);
    acc(0, 0, 'h0E, 0); check("R3 ctrl set via mmio", rd, 64'h8400_0000_0000_00AF);
    acc(1, 1, 'h13, 64'h8000_0000_0000_0005);
    acc(1, 0, 'h0E, 0); check("R3 ctrl clear", rd, 64'h0400_0000_0000_00AA);
    acc(0, 0, 'h12, 0); check("R8 set alias read", rd, ONES);
  endtask

  task automatic t_base;
    acc(0, 1, 'h0A, 64'hFFFF_FFFF_FFFF_FFFE);
    check("R4 window disabled", {63'd0, window_valid}, 64'd0);
    check("R4 window base", window_base, ADDRMSK);
    acc(1, 0, 'h0A, 0); check("R4 base mmio read", rd, ADDRMSK);
    acc(0, 1, 'h0A, 64'h0000_1234_5678_9ABD);
    check("R4 window enabled", {63'd0, window_valid}, 64'd1);
    check("R4 window base2", window_base, 64'h0000_1234_5670_0000);
    acc(1, 1, 'h0A, 64'h0);
    check("R5 mmio base err", {63'd0, er}, 64'd1);
    check("R5 window kept", window_base, 64'h0000_1234_5670_0000);
    check("R5 valid kept", {63'd0, window_valid}, 64'd1);
  endtask

  task automatic t_side;
    acc(1, 1, 'h0B, ONES);
    acc(0, 0, 'h0B, 0); check("R6 side base mask", rd, SIDEMSK);
  endtask

  task automatic t_istat;
    acc(0, 1, 'h15, ONES); check("R7 istat write err", {63'd0, er}, 64'd1);
    acc(1, 0, 'h15, 0);    check("R7 istat reads zero", rd, 64'd0);
    check("R7 istat read ok", {63'd0, er}, 64'd0);
  endtask

  task automatic t_unimpl;
    acc(0, 0, 'h30, 0); check("R8 unimpl read", rd, ONES);
    check("R8 unimpl err", {63'd0, er}, 64'd1);
    acc(0, 1, 'h0F, ONES); check("R8 unimpl write err", {63'd0, er}, 64'd1);
    acc(0, 0, 'h0E, 0); check("R8 ctrl untouched", rd, 64'h0400_0000_0000_00AA);
  endtask

  task automatic t_size;
    acc(0, 1, 'h00, 64'd0, 4'd4); check("R9 short write err", {63'd0, er}, 64'd1);
    acc(0, 0, 'h00, 0); check("R9 fault untouched", rd, 64'hF000_0001_0F0F_1235);
    acc(0, 0, 'h00, 0, 4'd2); check("R9 short read ones", rd, ONES);
    check("R9 short read err", {63'd0, er}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fault;
    t_ctrl;
    t_base;
    t_side;
    t_istat;
    t_unimpl;
    t_size;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule